// File: doc/BRIEF.md
# Ethernet Receive Address Filter

The filter decides, for every received frame, whether it is handed on or dropped, based on the 48-bit destination address and an optional check of the source address. The receive path presents both addresses in one cycle with `frm_valid`. Exactly two clock cycles later the block returns one decision pulse. The pulse carries a pass flag and two fail flags, one for the destination check and one for the source check.

The destination check depends on the address class. A unicast address must equal an enabled entry in a bank of perfect-match slots. Slot 0 is meant for the station's own address and the remaining slots hold extra unicast addresses. A multicast address is accepted when the pass-all-multicast mode is on. Failing that, it is accepted when the hash filter is on and the bin selected by a CRC-32 of the address is set in a 64-bit hash table. The broadcast address is accepted unless broadcast is disabled. Promiscuous mode overrides everything. Receive-all mode passes every frame but still reports the outcome of the checks.

Configuration is written through three independent write ports: a mode word, the two 32-bit hash words, and the address slots. Software is expected to change the configuration only while no frame is in flight.

Top module: `rx_addr_filter`

## Requirements
- R1: A frame presented with `frm_valid` high at clock edge N produces exactly one `dec_valid` pulse at edge N+2, and `dec_valid` is low in every other cycle.
- R2: With mode bit 0 (promiscuous) set, every frame passes with both fail flags low, whatever the other mode bits and the addresses are.
- R3: With mode bit 3 (receive-all) set and bit 0 clear, every frame passes, and `dec_da_fail`/`dec_sa_fail` still show the outcome of the destination and source checks.
- R4: The broadcast address (all 48 bits one) passes the destination check unless mode bit 4 (broadcast disable) is set, in which case it fails.
- R5: With mode bit 1 (pass-all-multicast) set, any non-broadcast address whose group bit is set passes the destination check. The group bit is bit 0 of `frm_da`, the first address byte being `frm_da[7:0]`.
- R6: With mode bit 2 (hash enable) set, a non-broadcast multicast address passes the destination check exactly when the addressed hash bit is 1. The bin index is taken from the reflected CRC-32 (polynomial 0xEDB88320, register preset to all ones) computed over the 48 address bits, starting with `frm_da[0]`, and then complemented. Index bit 5-k equals bit k of the complemented register. Index bit 5 picks the high word (`hash_sel`=1) or the low word, and index bits 4:0 pick the bit within that word. With bits 1 and 2 both clear, a non-broadcast multicast address fails.
- R7: A unicast destination address passes the destination check exactly when it equals the address of an enabled slot, for any of the 17 slots (index 0 and 1 to 16).
- R8: A slot written with `slot_wen`=0 never matches, and after reset all slots are disabled.
- R9: With mode bit 5 (source check) set, `dec_sa_fail` is high when `frm_sa` equals no enabled slot. Without promiscuous or receive-all mode, a frame passes only when its destination check succeeds and its source check does not fail.
- R10: After reset the mode word and both hash words are zero, and `dec_valid`, `dec_pass`, `dec_da_fail` and `dec_sa_fail` are low whenever no decision is being reported.
- R11: A slot write with an index above 16 changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | 6 | Mode word: bit0 promiscuous, bit1 pass-all-multicast, bit2 hash enable, bit3 receive-all, bit4 broadcast disable, bit5 source check |
| hash_we | input | 1 | Hash word write strobe |
| hash_sel | input | 1 | Hash word select: 1 high, 0 low |
| hash_wdata | input | 32 | Hash word data |
| slot_we | input | 1 | Address slot write strobe |
| slot_idx | input | 5 | Slot index, 0 to 16 valid |
| slot_wen | input | 1 | Enable bit written into the slot |
| slot_waddr | input | 48 | Address written into the slot, first byte in bits 7:0 |
| frm_valid | input | 1 | Address pair valid |
| frm_da | input | 48 | Destination address, first byte in bits 7:0 |
| frm_sa | input | 48 | Source address, same byte order |
| dec_valid | output | 1 | Decision valid, two cycles after `frm_valid` |
| dec_pass | output | 1 | Frame is accepted |
| dec_da_fail | output | 1 | Destination check failed |
| dec_sa_fail | output | 1 | Source check failed |

## Verification
The hash filter is swept with several hundred multicast addresses under table patterns that are sparse, dense and alternating. This shows that the bin index (the CRC, the complement, the bit reversal and the word select) picks the one correct bit, and not a neighbouring or mirrored one. Every one of the 17 slots is hit with its own address and missed with an address differing in a single byte, which separates a true compare from a partial one. A disabled slot and an out-of-range slot write show that the enable and the index bound are obeyed. The same unmatched address is then sent under each mode word in turn: plain, broadcast disable, pass-all-multicast, source check, receive-all and promiscuous. Comparing the three output flags across these runs shows the order in which the modes take precedence.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

  localparam int ADDR_W = 48;
  localparam int MODE_W = 6;
  localparam int HASH_W = 32;
  localparam int BIN_W  = 6;

  // mode word bit positions
  localparam int MB_PROMISC = 0;
  localparam int MB_ALLMC   = 1;
  localparam int MB_HASH    = 2;
  localparam int MB_RXALL   = 3;
  localparam int MB_NOBCAST = 4;
  localparam int MB_SACHK   = 5;

  typedef struct packed {
    logic pass;
    logic da_fail;
    logic sa_fail;
  } verdict_t;

  // Reflected CRC-32 over the address, LSB of first byte first, preset
  // all ones; bin = top six bits of the bit-reversed complement.
  function automatic logic [BIN_W-1:0] hash_bin(input logic [ADDR_W-1:0] a);
    logic [31:0] c;
    logic fb;
    logic [BIN_W-1:0] b;
    c = '1;
    for (int i = 0; i < ADDR_W; i++) begin
      fb = c[0] ^ a[i];
      c  = c >> 1;
      if (fb) c = c ^ 32'hEDB8_8320;
    end
    c = ~c;
    for (int k = 0; k < BIN_W; k++) b[BIN_W-1-k] = c[k];
    return b;
  endfunction

  // Combines the class results with the mode word.
  function automatic verdict_t decide(input logic [MODE_W-1:0] m,
                                      input logic bcast, input logic group,
                                      input logic uc_hit, input logic hash_hit,
                                      input logic sa_hit);
    verdict_t v;
    logic da_ok, sa_bad;
    if (bcast)      da_ok = ~m[MB_NOBCAST];
    else if (group) da_ok = m[MB_ALLMC] | (m[MB_HASH] & hash_hit);
    else            da_ok = uc_hit;
    sa_bad = m[MB_SACHK] & ~sa_hit;
    if (m[MB_PROMISC]) begin
      v = '{pass: 1'b1, da_fail: 1'b0, sa_fail: 1'b0};
    end else begin
      v.da_fail = ~da_ok;
      v.sa_fail = sa_bad;
      v.pass    = m[MB_RXALL] | (da_ok & ~sa_bad);
    end
    return v;
  endfunction

endpackage

// File: rtl/rxaf_slot_bank.sv
module rxaf_slot_bank #(
  parameter int NUM_SLOTS = 17,
  parameter int IDX_W     = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [IDX_W-1:0]           idx,
  input  logic                       wen,
  input  logic [rxaf_pkg::ADDR_W-1:0] waddr,
  input  logic [rxaf_pkg::ADDR_W-1:0] da,
  input  logic [rxaf_pkg::ADDR_W-1:0] sa,
  output logic [NUM_SLOTS-1:0]       da_hit,
  output logic [NUM_SLOTS-1:0]       sa_hit
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

  logic [rxaf_pkg::ADDR_W-1:0] slot_addr [NUM_SLOTS];
  logic [NUM_SLOTS-1:0]        slot_en;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_addr[g] <= '0;
        slot_en[g]   <= 1'b0;
      end else if (we && idx <= LAST_IDX && idx == IDX_W'(g)) begin
        slot_addr[g] <= waddr;
        slot_en[g]   <= wen;
      end
    end
    assign da_hit[g] = slot_en[g] && (slot_addr[g] == da);
    assign sa_hit[g] = slot_en[g] && (slot_addr[g] == sa);
  end

endmodule

// File: rtl/rxaf_hash_table.sv
module rxaf_hash_table (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic                       sel_hi,
  input  logic [rxaf_pkg::HASH_W-1:0] wdata,
  input  logic [rxaf_pkg::BIN_W-1:0]  bin,
  output logic                       bit_set
);
  logic [rxaf_pkg::HASH_W-1:0] word_lo, word_hi, word_pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_lo <= '0;
      word_hi <= '0;
    end else if (we) begin
      if (sel_hi) word_hi <= wdata;
      else        word_lo <= wdata;
    end
  end

  assign word_pick = bin[rxaf_pkg::BIN_W-1] ? word_hi : word_lo;
  assign bit_set   = word_pick[bin[rxaf_pkg::BIN_W-2:0]];

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter  int EXTRA_SLOTS = 16,
  localparam int NUM_SLOTS   = EXTRA_SLOTS + 1,
  localparam int SLOT_IDX_W  = $clog2(NUM_SLOTS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          mode_we,
  input  logic [rxaf_pkg::MODE_W-1:0]   mode_wdata,
  input  logic                          hash_we,
  input  logic                          hash_sel,
  input  logic [rxaf_pkg::HASH_W-1:0]   hash_wdata,
  input  logic                          slot_we,
  input  logic [SLOT_IDX_W-1:0]         slot_idx,
  input  logic                          slot_wen,
  input  logic [rxaf_pkg::ADDR_W-1:0]   slot_waddr,
  input  logic                          frm_valid,
  input  logic [rxaf_pkg::ADDR_W-1:0]   frm_da,
  input  logic [rxaf_pkg::ADDR_W-1:0]   frm_sa,
  output logic                          dec_valid,
  output logic                          dec_pass,
  output logic                          dec_da_fail,
  output logic                          dec_sa_fail
);
  import rxaf_pkg::*;

  logic [MODE_W-1:0]    mode_q;
  logic [NUM_SLOTS-1:0] da_hit_vec, sa_hit_vec;
  logic                 hash_hit;

  // stage 1 state (named for the checker)
  logic             s1_vld, s1_bcast, s1_group, s1_uc_hit, s1_sa_hit;
  logic [BIN_W-1:0] s1_bin;
  verdict_t         s2_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= mode_wdata;
  end

  rxaf_slot_bank #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(SLOT_IDX_W)) u_slots (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (slot_we),
    .idx    (slot_idx),
    .wen    (slot_wen),
    .waddr  (slot_waddr),
    .da     (frm_da),
    .sa     (frm_sa),
    .da_hit (da_hit_vec),
    .sa_hit (sa_hit_vec)
  );

  rxaf_hash_table u_hash (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (hash_we),
    .sel_hi  (hash_sel),
    .wdata   (hash_wdata),
    .bin     (s1_bin),
    .bit_set (hash_hit)
  );

  // stage 1: address compares and CRC bin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld    <= 1'b0;
      s1_bcast  <= 1'b0;
      s1_group  <= 1'b0;
      s1_uc_hit <= 1'b0;
      s1_sa_hit <= 1'b0;
      s1_bin    <= '0;
    end else begin
      s1_vld <= frm_valid;
      if (frm_valid) begin
        s1_bcast  <= &frm_da;
        s1_group  <= frm_da[0];
        s1_uc_hit <= |da_hit_vec;
        s1_sa_hit <= |sa_hit_vec;
        s1_bin    <= hash_bin(frm_da);
      end
    end
  end

  // stage 2: hash lookup and mode combination
  always_comb begin
    s2_next = decide(mode_q, s1_bcast, s1_group, s1_uc_hit, hash_hit, s1_sa_hit);
    if (!s1_vld) s2_next = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid   <= 1'b0;
      dec_pass    <= 1'b0;
      dec_da_fail <= 1'b0;
      dec_sa_fail <= 1'b0;
    end else begin
      dec_valid   <= s1_vld;
      dec_pass    <= s2_next.pass;
      dec_da_fail <= s2_next.da_fail;
      dec_sa_fail <= s2_next.sa_fail;
    end
  end

endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        frm_valid,
  input logic                        s1_vld,
  input logic [rxaf_pkg::MODE_W-1:0] mode_q,
  input logic                        dec_valid,
  input logic                        dec_pass,
  input logic                        dec_da_fail,
  input logic                        dec_sa_fail
);
  import rxaf_pkg::*;

  // R1
  stage1_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> s1_vld);

  // R1
  decision_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> dec_valid);

  // R1
  no_spurious_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> !dec_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_pass && !dec_da_fail && !dec_sa_fail);

  // R2
  promisc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && $stable(mode_q) && mode_q[MB_PROMISC]
      |-> dec_pass && !dec_da_fail && !dec_sa_fail);

  // R3
  rxall_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && $stable(mode_q) && mode_q[MB_RXALL] |-> dec_pass);

  // R9
  fail_blocks_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && $stable(mode_q) && !mode_q[MB_PROMISC] && !mode_q[MB_RXALL]
      && (dec_da_fail || dec_sa_fail) |-> !dec_pass);

endmodule

bind rx_addr_filter rx_addr_filter_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frm_valid   (frm_valid),
  .s1_vld      (s1_vld),
  .mode_q      (mode_q),
  .dec_valid   (dec_valid),
  .dec_pass    (dec_pass),
  .dec_da_fail (dec_da_fail),
  .dec_sa_fail (dec_sa_fail)
);

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
  localparam int NS = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 0;
  logic [5:0]  mode_wdata = '0;
  logic        hash_we = 0, hash_sel = 0;
  logic [31:0] hash_wdata = '0;
  logic        slot_we = 0, slot_wen = 0;
  logic [4:0]  slot_idx = '0;
  logic [47:0] slot_waddr = '0;
  logic        frm_valid = 0;
  logic [47:0] frm_da = '0, frm_sa = '0;
  logic        dec_valid, dec_pass, dec_da_fail, dec_sa_fail;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model of the configuration
  logic [5:0]  m_mode = '0;
  logic [31:0] m_lo = '0, m_hi = '0;
  logic [47:0] m_addr [NS];
  logic        m_en [NS];

  always #10 clk = ~clk;

  rx_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .hash_we(hash_we), .hash_sel(hash_sel), .hash_wdata(hash_wdata),
    .slot_we(slot_we), .slot_idx(slot_idx), .slot_wen(slot_wen), .slot_waddr(slot_waddr),
    .frm_valid(frm_valid), .frm_da(frm_da), .frm_sa(frm_sa),
    .dec_valid(dec_valid), .dec_pass(dec_pass),
    .dec_da_fail(dec_da_fail), .dec_sa_fail(dec_sa_fail)
  );

  // Forward (non-reflected) CRC fed with the same bit order; its register
  // is the mirror image of the reflected one, so the bin is its top bits.
  function automatic logic [5:0] bench_bin(input logic [47:0] a);
    logic [31:0] c;
    logic fb;
    c = '1;
    for (int i = 0; i < 48; i++) begin
      fb = c[31] ^ a[i];
      c = c << 1;
      if (fb) c = c ^ 32'h04C1_1DB7;
    end
    c = ~c;
    return c[31:26];
  endfunction

  function automatic bit slot_hit(input logic [47:0] a);
    for (int s = 0; s < NS; s++) if (m_en[s] && m_addr[s] == a) return 1;
    return 0;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr_mode(input logic [5:0] m);
    @(negedge clk); mode_we = 1; mode_wdata = m;
    @(negedge clk); mode_we = 0; m_mode = m;
  endtask

  task automatic wr_hash(input logic [31:0] lo, input logic [31:0] hi);
    @(negedge clk); hash_we = 1; hash_sel = 0; hash_wdata = lo;
    @(negedge clk); hash_sel = 1; hash_wdata = hi;
    @(negedge clk); hash_we = 0; m_lo = lo; m_hi = hi;
  endtask

  task automatic wr_slot(input int idx, input logic en, input logic [47:0] a);
    @(negedge clk); slot_we = 1; slot_idx = 5'(idx); slot_wen = en; slot_waddr = a;
    @(negedge clk); slot_we = 0;
    if (idx < NS) begin m_en[idx] = en; m_addr[idx] = a; end // R11: others ignored
  endtask

  task automatic send(input string tag, input logic [47:0] da, input logic [47:0] sa);
    logic da_ok, sa_bad, e_pass, e_daf, e_saf;
    logic [5:0] b;
    b = bench_bin(da);
    if (da == '1)    da_ok = !m_mode[4];
    else if (da[0])  da_ok = m_mode[1] || (m_mode[2] && (b[5] ? m_hi[b[4:0]] : m_lo[b[4:0]]));
    else             da_ok = slot_hit(da);
    sa_bad = m_mode[5] && !slot_hit(sa);
    if (m_mode[0]) begin e_pass = 1; e_daf = 0; e_saf = 0; end
    else begin e_daf = !da_ok; e_saf = sa_bad; e_pass = m_mode[3] || (da_ok && !sa_bad); end
    @(negedge clk); frm_valid = 1; frm_da = da; frm_sa = sa;
    @(negedge clk); frm_valid = 0;
    @(negedge clk);
    check({tag, " R1 valid"}, 32'(dec_valid), 32'd1);
    check({tag, " {pass,daf,saf}"}, {29'd0, dec_pass, dec_da_fail, dec_sa_fail},
          {29'd0, e_pass, e_daf, e_saf});
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [47:0] a;
    for (int s = 0; s < NS; s++) begin m_en[s] = 0; m_addr[s] = '0; end
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset dec", {28'd0, dec_valid, dec_pass, dec_da_fail, dec_sa_fail}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R10 idle after reset", {28'd0, dec_valid, dec_pass, dec_da_fail, dec_sa_fail}, 32'd0);

    // R8 all slots disabled after reset; R4 broadcast passes by default
    send("R8 unicast no slots", 48'h6655_4433_2210, 48'h0);
    send("R4 broadcast default", '1, 48'h0);
    // R6 hash off and all-multicast off: multicast fails with zero mode
    send("R6 multicast no mode", 48'h0000_5E00_0001, 48'h0);

    // R7 fill every slot, sweep hits and single-byte misses
    for (int s = 0; s < NS; s++) wr_slot(s, 1, {8'(s * 7 + 3), 40'h12_3456_7800 + 40'(s << 1)});
    for (int s = 0; s < NS; s++) begin
      a = m_addr[s];
      send("R7 slot hit", a, 48'h0);
      send("R7 slot miss", a ^ 48'h0000_0100_0000, 48'h0);
    end
    // R11 write beyond last slot is ignored
    wr_slot(31, 1, 48'hABCD_EF01_2300);
    wr_slot(NS, 1, 48'hABCD_EF01_2302);
    send("R11 idx31 ignored", 48'hABCD_EF01_2300, 48'h0);
    send("R11 idx17 ignored", 48'hABCD_EF01_2302, 48'h0);
    // R8 disable slot 5, keep its address
    a = m_addr[5];
    wr_slot(5, 0, a);
    send("R8 disabled slot", a, 48'h0);
    send("R8 slot 6 still hits", m_addr[6], 48'h0);

    // R4 broadcast disable
    wr_mode(6'b01_0000);
    send("R4 broadcast disabled", '1, 48'h0);
    send("R4 unicast with bcast off", m_addr[0], 48'h0);

    // R6 hash sweep under several table patterns
    wr_mode(6'b00_0100);
    for (int p = 0; p < 4; p++) begin
      case (p)
        0: wr_hash(32'h0000_0001, 32'h8000_0000);
        1: wr_hash(32'hA5A5_5A5A, 32'h0F0F_F0F0);
        2: wr_hash(32'hFFFF_FFFF, 32'h0000_0000);
        default: wr_hash(32'h0000_0000, 32'hFFFF_FFFF);
      endcase
      for (int k = 0; k < 96; k++) begin
        a = (48'h0003_0507_0B0D * 48'(k + 1 + p * 131)) ^ 48'h1357_9BDF_0240;
        a[0] = 1'b1;
        if (a == '1) a[1] = 1'b0;
        send("R6 hash bin", a, 48'h0);
      end
    end
    // R6 hash table full but hash disabled
    wr_hash('1, '1);
    wr_mode(6'b00_0000);
    send("R6 hash disabled", 48'h0000_5E00_0001, 48'h0);

    // R5 pass-all-multicast
    wr_hash('0, '0);
    wr_mode(6'b00_0010);
    for (int k = 0; k < 8; k++) send("R5 all multicast", 48'h1111_2222_3301 + 48'(k << 9), 48'h0);
    send("R5 unicast still filtered", 48'h1111_2222_3300, 48'h0);

    // R9 source check
    wr_mode(6'b10_0000);
    send("R9 sa known", m_addr[0], m_addr[16]);
    send("R9 sa unknown", m_addr[0], 48'h0A0B_0C0D_0E00);
    send("R9 sa disabled slot", m_addr[0], m_addr[5]);
    send("R9 both fail", 48'h0A0B_0C0D_0E10, 48'h0A0B_0C0D_0E00);

    // R3 receive-all still reports
    wr_mode(6'b10_1000);
    send("R3 rxall both fail", 48'h0A0B_0C0D_0E10, 48'h0A0B_0C0D_0E00);
    send("R3 rxall clean", m_addr[1], m_addr[2]);
    wr_mode(6'b01_1000);
    send("R3 rxall bcast off", '1, 48'h0);

    // R2 promiscuous overrides all
    wr_mode(6'b11_1111);
    send("R2 promisc", 48'h0A0B_0C0D_0E10, 48'h0A0B_0C0D_0E00);
    wr_mode(6'b11_0001);
    send("R2 promisc bcast off", '1, 48'h0A0B_0C0D_0E00);

    // R1 decision is a single pulse
    @(negedge clk);
    check("R1 single pulse", 32'(dec_valid), 32'd0);
    // R1 back-to-back frames each produce a pulse
    wr_mode(6'b00_0000);
    @(negedge clk); frm_valid = 1; frm_da = m_addr[3];
    @(negedge clk); frm_da = 48'h0A0B_0C0D_0E10;
    @(negedge clk); frm_valid = 0;
    check("R1 b2b first", {30'd0, dec_valid, dec_pass}, 32'b11);
    @(negedge clk);
    check("R1 b2b second", {30'd0, dec_valid, dec_pass}, 32'b10);
    @(negedge clk);
    check("R1 b2b end R10", {28'd0, dec_valid, dec_pass, dec_da_fail, dec_sa_fail}, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule